// File: doc/BRIEF.md
# Video Prefetch Arbiter

This block shares one memory between a video prefetch engine and a CPU. The prefetch side reads display words in address order at the full memory rate and pushes them into a small pixel queue. The display pulls words out of the queue at the pixel rate, but only while the active-video strobe is high. A CPU access is allowed to start only when the queue holds enough words to feed the display for the whole length of that access. While the CPU owns the memory, prefetch reads pause. When the queue is too shallow, the CPU request waits.

During horizontal and vertical blanking nothing is drained, so the queue fills up and stays full. From then on every memory cycle is free for the CPU. At the rising edge of vertical blanking, the prefetch address goes back to the frame base and the queue is flushed, so the next frame starts from its first word. A sticky underrun flag records any pull from an empty queue during active video.

The memory port is a single-cycle, asynchronous-read port: the address and strobes go out, and the read data comes back in the same cycle. The controller has two states. In `ST_FETCH` it either issues one prefetch read or grants the CPU its first access cycle. A multi-cycle grant moves it to `ST_CPU`, where it counts the remaining access cycles and returns to `ST_FETCH` on the last one.

Top module: `vpf_arbiter`

## Requirements
- R1: While `rst` is high, `cpu_ready` and `underrun` are 0, `mem_we` is 0 with `cpu_req` low, and `mem_addr` equals `frame_base`.
- R2: In `ST_FETCH`, with no CPU grant, no vertical-blanking rise and a queue that is not full, `mem_re` is 1 and `mem_addr` is the prefetch address. That address starts at `frame_base` after reset and increments by one for each prefetch read.
- R3: With DEPTH words queued, no prefetch read is issued, and the queue never holds more than DEPTH words.
- R4: `pix_data` shows the oldest queued word, in prefetch order. A word is removed only when `pix_pop` and `vid_active` are both 1 and the queue is not empty. `pix_pop` with `vid_active` at 0 leaves the queue unchanged.
- R5: In `ST_FETCH`, a CPU request is granted in the same cycle only if the queue level is at least `cfg_thresh`. Otherwise the CPU stalls and prefetch continues.
- R6: A granted access lasts exactly CPU_CYCLES consecutive cycles. In each of those cycles `mem_addr`=`cpu_addr`, `mem_we`=`cpu_we`, `mem_wdata`=`cpu_wdata`, and `mem_re`=!`cpu_we`, with no prefetch read. `cpu_ready` is 1 only in the final cycle, where `cpu_rdata` equals the memory word at `cpu_addr`.
- R7: When blanking has filled the queue, a pending CPU request is granted at once. Back-to-back requests then each complete in CPU_CYCLES cycles with no gap.
- R8: In the cycle where `vid_vblank` rises, no prefetch read is issued. The queue is emptied, and the next prefetch read uses `frame_base`.
- R9: `underrun` becomes 1 on the cycle after `pix_pop` and `vid_active` are 1 with an empty queue. It stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one memory cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| cfg_thresh | input | LW (5) | Minimum queue level for a CPU grant; held stable |
| frame_base | input | AW (10) | First word address of the frame |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW (10) | CPU word address |
| cpu_wdata | input | DW (8) | CPU write data |
| cpu_ready | output | 1 | Final cycle of the CPU access |
| cpu_rdata | output | DW (8) | CPU read data, valid with `cpu_ready` |
| vid_active | input | 1 | Active-video strobe |
| vid_vblank | input | 1 | Vertical blanking level |
| pix_pop | input | 1 | Pixel word pull request |
| pix_data | output | DW (8) | Oldest queued display word |
| underrun | output | 1 | Sticky empty-pull flag |
| mem_addr | output | AW (10) | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW (8) | Memory write data |
| mem_rdata | input | DW (8) | Memory read data, same cycle |

## Verification
A CPU grant and a pixel pull can land in the same cycle. The grant is judged against the queue level before that pull, so a threshold below CPU_CYCLES can drain the queue and raise `underrun`. The bench provokes this by sweeping every threshold from 0 to DEPTH against several pull rates while the CPU requests continually. A bench-side queue model decides, every cycle, whether a grant, a prefetch read, a pull or an underrun is due, and compares `mem_addr`, the strobes, `cpu_ready`, `pix_data` and `underrun` against it.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
    typedef enum logic [0:0] {
        ST_FETCH = 1'b0,
        ST_CPU   = 1'b1
    } vpf_state_e;
endpackage

// File: rtl/vpf_fifo.sv
module vpf_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [LW-1:0] level_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_q    <= '0;
            rd_q    <= '0;
            level_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
            level_q <= level_q + LW'(push) - LW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) store[wr_q] <= push_data;
    end

    assign head  = store[rd_q];
    assign level = level_q;
    assign full  = (level_q == LW'(DEPTH));
    assign empty = (level_q == '0);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level_q <= LW'(DEPTH)); // R3
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty); // R4
endmodule

// File: rtl/vpf_addr_gen.sv
module vpf_addr_gen #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base,
    input  logic          reload,
    input  logic          advance,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || reload)  addr_q <= base;
        else if (advance)   addr_q <= addr_q + 1'b1;
    end

    assign addr = addr_q;
endmodule

// File: rtl/vpf_arb_fsm.sv
module vpf_arb_fsm
    import vpf_pkg::*;
#(
    parameter int CPU_CYCLES = 2,
    parameter int LW         = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] thresh,
    input  logic          fifo_full,
    input  logic          vb_rise,
    output logic          cpu_sel,
    output logic          cpu_last,
    output logic          fill
);
    localparam int CW = (CPU_CYCLES > 1) ? $clog2(CPU_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CPU_CYCLES - 1);

    vpf_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        cpu_sel  = 1'b0;
        cpu_last = 1'b0;
        fill     = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                if (cpu_req && (level >= thresh)) begin
                    cpu_sel = 1'b1;
                    if (CPU_CYCLES == 1) begin
                        cpu_last = 1'b1;
                    end else begin
                        state_d = ST_CPU;
                        cnt_d   = CW'(1);
                    end
                end else begin
                    fill = !fifo_full && !vb_rise;
                end
            end
            ST_CPU: begin
                cpu_sel = 1'b1;
                if (cnt_q == CNT_LAST) begin
                    cpu_last = 1'b1;
                    state_d  = ST_FETCH;
                    cnt_d    = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_FETCH;
        endcase
    end

    AST_CPU_STATE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CPU && cnt_q == CW'(1)) |-> $past(cpu_req)); // R6
endmodule

// File: rtl/vpf_arbiter.sv
module vpf_arbiter
    import vpf_pkg::*;
#(
    parameter int DW         = 8,
    parameter int AW         = 10,
    parameter int DEPTH      = 16,
    parameter int CPU_CYCLES = 2,
    parameter int LW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] cfg_thresh,
    input  logic [AW-1:0] frame_base,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ready,
    output logic [DW-1:0] cpu_rdata,
    input  logic          vid_active,
    input  logic          vid_vblank,
    input  logic          pix_pop,
    output logic [DW-1:0] pix_data,
    output logic          underrun,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    logic          vblank_q, vb_rise;
    logic          underrun_q;
    logic          fill, cpu_sel, cpu_last;
    logic          fifo_full, fifo_empty, pop_ok;
    logic [LW-1:0] fifo_level;
    logic [AW-1:0] fetch_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            vblank_q   <= 1'b0;
            underrun_q <= 1'b0;
        end else begin
            vblank_q <= vid_vblank;
            if (pix_pop && vid_active && fifo_empty) underrun_q <= 1'b1;
        end
    end

    assign vb_rise = vid_vblank && !vblank_q;
    assign pop_ok  = pix_pop && vid_active && !fifo_empty;

    vpf_arb_fsm #(.CPU_CYCLES(CPU_CYCLES), .LW(LW)) i_fsm (
        .clk      (clk),
        .rst      (rst),
        .cpu_req  (cpu_req),
        .level    (fifo_level),
        .thresh   (cfg_thresh),
        .fifo_full(fifo_full),
        .vb_rise  (vb_rise),
        .cpu_sel  (cpu_sel),
        .cpu_last (cpu_last),
        .fill     (fill)
    );

    vpf_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) i_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (vb_rise),
        .push     (fill),
        .push_data(mem_rdata),
        .pop      (pop_ok),
        .head     (pix_data),
        .level    (fifo_level),
        .full     (fifo_full),
        .empty    (fifo_empty)
    );

    vpf_addr_gen #(.AW(AW)) i_addr (
        .clk    (clk),
        .rst    (rst),
        .base   (frame_base),
        .reload (vb_rise),
        .advance(fill),
        .addr   (fetch_addr)
    );

    assign mem_addr  = cpu_sel ? cpu_addr : fetch_addr;
    assign mem_re    = fill || (cpu_sel && !cpu_we);
    assign mem_we    = cpu_sel && cpu_we;
    assign mem_wdata = cpu_wdata;
    assign cpu_ready = cpu_sel && cpu_last;
    assign cpu_rdata = mem_rdata;
    assign underrun  = underrun_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !fill); // R3
    AST_GRANT_COVERED: assert property (@(posedge clk) disable iff (rst)
        (cpu_sel && !$past(cpu_sel)) |-> (fifo_level >= cfg_thresh)); // R5
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun); // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        vb_rise |=> (fifo_level == '0)); // R8
endmodule

// File: tb/test_vpf_arbiter.sv
module test_vpf_arbiter;
    localparam int PERIOD = 10;
    localparam int DW     = 8;
    localparam int AW     = 10;
    localparam int DEPTH  = 16;
    localparam int CPUC   = 2;
    localparam int LW     = $clog2(DEPTH + 1);
    localparam int NCYC   = 500;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [LW-1:0] cfg_thresh = '0;
    logic [AW-1:0] frame_base = '0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          vid_active = 1'b0, vid_vblank = 1'b0, pix_pop = 1'b0;
    logic [DW-1:0] pix_data;
    logic          underrun;
    logic [AW-1:0] mem_addr;
    logic          mem_re, mem_we;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic [DW-1:0] mem [1 << AW];
    int vectors = 0, fails = 0;

    always #(PERIOD / 2) clk = ~clk;

    vpf_arbiter #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .CPU_CYCLES(CPUC)) i_vpf_arbiter (
        .clk(clk), .rst(rst), .cfg_thresh(cfg_thresh), .frame_base(frame_base),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .vid_active(vid_active),
        .vid_vblank(vid_vblank), .pix_pop(pix_pop), .pix_data(pix_data),
        .underrun(underrun), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int m_level, m_cnt, k, gap;
        bit m_busy, m_under, m_vbq, prev_ready, prev_rise;
        logic [AW-1:0] m_addr;
        logic [DW-1:0] m_q[$];
        for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 3) ^ 8'hA5;
        for (int thr = 0; thr <= DEPTH; thr++) begin
            for (int p = 0; p < 4; p++) begin
                // reset phase, R1
                @(negedge clk);
                rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; pix_pop = 1'b0;
                vid_active = 1'b0; vid_vblank = 1'b0;
                cfg_thresh = LW'(thr);
                frame_base = AW'((thr * 37 + p * 101) % (1 << AW));
                for (int r = 0; r < 3; r++) begin
                    @(negedge clk); #1;
                    chk(cpu_ready == 1'b0, "R1 cpu_ready", cpu_ready, 0);
                    chk(underrun == 1'b0, "R1 underrun", underrun, 0);
                    chk(mem_we == 1'b0, "R1 mem_we", mem_we, 0);
                    chk(mem_addr == frame_base, "R1 mem_addr", mem_addr, frame_base);
                end
                @(negedge clk);
                rst = 1'b0;
                m_level = 0; m_cnt = 0; m_busy = 0; m_under = 0; m_vbq = 0;
                m_addr = frame_base; m_q.delete();
                prev_ready = 0; prev_rise = 0; k = 0; gap = 3;
                for (int t = 0; t < NCYC; t++) begin
                    bit vb_rise, go, phase, last, fill, popv, e_re;
                    int pos;
                    pos = t % 238;
                    vid_vblank = (pos >= 208);
                    vid_active = (pos < 208) && ((pos % 52) < 40);
                    pix_pop    = ((t % (p + 1)) == 0);
                    if (prev_ready) begin
                        cpu_req = 1'b0;
                        gap = (k * 5 + thr) % 4;
                    end else if (!cpu_req && gap == 0) begin
                        cpu_req   = 1'b1;
                        cpu_we    = ((k % 3) == 0);
                        cpu_addr  = AW'(frame_base + AW'((k * 13) % 64));
                        cpu_wdata = DW'(k * 7 + 1);
                        k++;
                    end else if (gap > 0) gap--;
                    #1;
                    vb_rise = vid_vblank && !m_vbq;
                    go      = !m_busy && cpu_req && (m_level >= thr);
                    phase   = m_busy || go;
                    last    = m_busy ? (m_cnt == CPUC - 1) : (CPUC == 1);
                    fill    = !phase && (m_level < DEPTH) && !vb_rise;
                    e_re    = fill || (phase && !cpu_we);
                    if (phase) begin
                        chk(mem_addr == cpu_addr, "R6 mem_addr", mem_addr, cpu_addr);
                        chk(mem_we == cpu_we, "R6 mem_we", mem_we, cpu_we);
                        chk(mem_re == e_re, "R6 mem_re", mem_re, e_re);
                        if (cpu_we) chk(mem_wdata == cpu_wdata, "R6 mem_wdata", mem_wdata, cpu_wdata);
                    end else begin
                        chk(mem_we == 1'b0, "R6 mem_we idle", mem_we, 0);
                        chk(mem_re == e_re, m_level == DEPTH ? "R3 mem_re" : "R2 mem_re", mem_re, e_re);
                        if (fill) chk(mem_addr == m_addr, prev_rise ? "R8 mem_addr" : "R2 mem_addr", mem_addr, m_addr);
                    end
                    chk(cpu_ready == (phase && last), m_busy ? "R6 cpu_ready" : "R5 cpu_ready", cpu_ready, phase && last);
                    if (phase && last && !cpu_we)
                        chk(cpu_rdata == mem[cpu_addr], "R6 cpu_rdata", cpu_rdata, mem[cpu_addr]);
                    if (!m_busy && cpu_req && m_level < thr)
                        chk(mem_we == 1'b0 && !(mem_addr == cpu_addr && !fill), "R5 stall", mem_we, 0);
                    if (!vid_active && m_level == DEPTH && !m_busy && cpu_req)
                        chk(mem_addr == cpu_addr, "R7 immediate grant", mem_addr, cpu_addr);
                    if (vb_rise) chk(mem_re == (phase && !cpu_we), "R8 no fetch on rise", mem_re, phase && !cpu_we);
                    popv = pix_pop && vid_active && (m_level > 0);
                    if (m_level > 0) chk(pix_data == m_q[0], "R4 pix_data", pix_data, m_q[0]);
                    chk(underrun == m_under, "R9 underrun", underrun, m_under);
                    prev_ready = cpu_ready;
                    if (pix_pop && vid_active && m_level == 0) m_under = 1;
                    if (vb_rise) begin
                        m_q.delete();
                        m_addr = frame_base;
                    end else begin
                        if (popv) void'(m_q.pop_front());
                        if (fill) begin
                            m_q.push_back(mem[m_addr]);
                            m_addr = m_addr + 1'b1;
                        end
                    end
                    m_level = m_q.size();
                    if (phase && !last) begin
                        m_cnt  = m_busy ? m_cnt + 1 : 1;
                        m_busy = 1;
                    end else begin
                        m_busy = 0;
                        m_cnt  = 0;
                    end
                    m_vbq = vid_vblank;
                    prev_rise = vb_rise;
                    @(negedge clk);
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule